// File: doc/BRIEF.md
# Bidirectional Connection Tracking Filter

This block is a two-stage firewall. It sits between a protected LAN port and a DMZ port. The first stage is stateful. It folds each packet's 4-tuple into a key that is the same in both directions. It looks that key up in a small direct-mapped flow table and updates the connection state it finds there. The second stage is stateless. It receives the stateful stage's verdict as packet metadata and decides whether the packet may pass.

Traffic that starts on the LAN side opens a tentative entry. The first reply from the DMZ side promotes that entry to established. After that, DMZ-to-LAN traffic for the flow is let through. A DMZ host that speaks first finds no entry, leaves no entry behind and is dropped. An aging tick input advances a per-entry idle count, and a flow that stays silent for a set number of ticks is forgotten.

Top module: `conn_track_filter`

## Requirements
- R1: `outValid` is high exactly three rising edges after the edge that sampled `inValid` high. It stays low when `inValid` was low at that sampling edge, and packets may be presented every cycle.
- R2: A packet endpoint is the concatenation {address, port}. The key is formed with the numerically smaller endpoint placed first, so both directions of a conversation find the same entry. The table slot is the low INDEX_W bits of srcPort XOR dstPort.
- R3: A LAN-side packet (`inFromDmz`=0) whose key misses its slot writes a tentative entry there and replaces any flow already in that slot. The entry records which endpoint order the LAN originator used. Such a packet reports `outEstablished`=0.
- R4: A DMZ-side packet that hits a tentative entry in the direction opposite to the originator's marks the entry established. That same packet is reported with `outEstablished`=1 and `outAccept`=1.
- R5: Every LAN-side packet has `outAccept`=1. Its `outEstablished` is 1 only when its entry was already established.
- R6: A DMZ-side packet has `outAccept` equal to its `outEstablished`. A DMZ-side packet that misses the table creates no entry, so a DMZ reply in the reverse direction is still dropped afterwards.
- R7: A DMZ-side packet that repeats the originator's direction does not establish a tentative entry. Once an entry is established, further packets from either side keep it established.
- R8: Each `ageTick` pulse increments the idle count of every valid entry. Any packet that hits the entry clears the count. An entry is cleared when its count reaches IDLE_LIMIT, which means a reply after IDLE_LIMIT-1 silent ticks still establishes the flow and a reply after IDLE_LIMIT silent ticks is dropped.
- R9: After reset the table is empty and `outValid`, `outEstablished` and `outAccept` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A packet header is present this cycle |
| inFromDmz | input | 1 | Ingress side: 1 = DMZ, 0 = LAN |
| inSrcAddr | input | ADDR_W | Source address |
| inDstAddr | input | ADDR_W | Destination address |
| inSrcPort | input | PORT_W | Source port |
| inDstPort | input | PORT_W | Destination port |
| ageTick | input | 1 | Aging strobe, one idle step per high cycle |
| outValid | output | 1 | A verdict is present |
| outEstablished | output | 1 | The packet's connection is established (metadata) |
| outAccept | output | 1 | Forward the packet; 0 means drop |

## Verification
Each verdict appears three edges after the edge that sampled the packet: one edge registers the key, one updates the table and the metadata, and one registers the filter decision. The bench presents a packet, drops `inValid` after the first edge, and samples the outputs at the falling edge that follows the third edge. It then checks one cycle later that `outValid` has fallen. Aging ticks are issued only while the pipeline is empty, so the reference model can apply packets and ticks in a strict order. A back-to-back case is still needed to confirm that a reply to a flow opened in the previous cycle sees the updated entry.

// File: rtl/ct_pkg.sv
package ct_pkg;

  // Table actions requested by the control for the slot under lookup
  typedef struct packed {
    logic wrNew;    // write a fresh tentative entry
    logic markEst;  // promote the hit entry to established
    logic refresh;  // clear the idle count of the hit entry
  } ctStrobe_t;

endpackage

// File: rtl/ct_datapath.sv
module ct_datapath
  import ct_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PORT_W     = 16,
  parameter int INDEX_W    = 4,
  parameter int IDLE_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inFromDmz,
  input  logic [ADDR_W-1:0] inSrcAddr,
  input  logic [ADDR_W-1:0] inDstAddr,
  input  logic [PORT_W-1:0] inSrcPort,
  input  logic [PORT_W-1:0] inDstPort,
  input  logic              ageTick,
  input  ctStrobe_t         stb,
  output logic              s1Valid,
  output logic              s1FromDmz,
  output logic              s1Swap,
  output logic              lkHit,
  output logic              lkEst,
  output logic              lkOrig
);

  localparam int EP_W   = ADDR_W + PORT_W;
  localparam int KEY_W  = 2 * EP_W;
  localparam int DEPTH  = 1 << INDEX_W;
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_LIMIT - 1);

  // Symmetric key: smaller endpoint first
  logic [EP_W-1:0]    epSrc, epDst;
  logic               swapIn;
  logic [KEY_W-1:0]   keyIn;
  logic [INDEX_W-1:0] idxIn;

  assign epSrc  = {inSrcAddr, inSrcPort};
  assign epDst  = {inDstAddr, inDstPort};
  assign swapIn = epSrc > epDst;
  assign keyIn  = swapIn ? {epDst, epSrc} : {epSrc, epDst};
  assign idxIn  = inSrcPort[INDEX_W-1:0] ^ inDstPort[INDEX_W-1:0];

  // Stage 1 registers
  logic [KEY_W-1:0]   s1Key;
  logic [INDEX_W-1:0] s1Idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid   <= 1'b0;
      s1FromDmz <= 1'b0;
      s1Swap    <= 1'b0;
      s1Key     <= '0;
      s1Idx     <= '0;
    end else begin
      s1Valid   <= inValid;
      s1FromDmz <= inFromDmz;
      s1Swap    <= swapIn;
      s1Key     <= keyIn;
      s1Idx     <= idxIn;
    end
  end

  // Flow table: one register set per slot
  logic [DEPTH-1:0]            entValid, entEst, entOrig;
  logic [DEPTH-1:0][KEY_W-1:0] entKey;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              eValid, eEst, eOrig, sel;
    logic [KEY_W-1:0]  eKey;
    logic [IDLE_W-1:0] eIdle;

    assign sel = s1Valid && (s1Idx == INDEX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        eValid <= 1'b0;
        eEst   <= 1'b0;
        eOrig  <= 1'b0;
        eKey   <= '0;
        eIdle  <= '0;
      end else if (sel && stb.wrNew) begin
        eValid <= 1'b1;
        eEst   <= 1'b0;
        eOrig  <= s1Swap;
        eKey   <= s1Key;
        eIdle  <= '0;
      end else if (sel && stb.markEst) begin
        eEst   <= 1'b1;
        eIdle  <= '0;
      end else if (sel && stb.refresh) begin
        eIdle  <= '0;
      end else if (ageTick && eValid) begin
        if (eIdle == IDLE_LAST) begin
          eValid <= 1'b0;
          eEst   <= 1'b0;
          eIdle  <= '0;
        end else begin
          eIdle  <= eIdle + 1'b1;
        end
      end
    end

    assign entValid[i] = eValid;
    assign entEst[i]   = eEst;
    assign entOrig[i]  = eOrig;
    assign entKey[i]   = eKey;
  end

  // Lookup of the slot addressed by stage 1
  assign lkHit  = entValid[s1Idx] && (entKey[s1Idx] == s1Key);
  assign lkEst  = entEst[s1Idx];
  assign lkOrig = entOrig[s1Idx];

endmodule

// File: rtl/ct_control.sv
module ct_control
  import ct_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      s1Valid,
  input  logic      s1FromDmz,
  input  logic      s1Swap,
  input  logic      lkHit,
  input  logic      lkEst,
  input  logic      lkOrig,
  output ctStrobe_t stb,
  output logic      metaValid,
  output logic      metaFromDmz,
  output logic      metaEst
);

  logic estNext;

  always_comb begin
    stb     = '0;
    estNext = 1'b0;
    if (s1Valid) begin
      if (!s1FromDmz) begin
        if (!lkHit) begin
          stb.wrNew = 1'b1;
        end else begin
          stb.refresh = 1'b1;
          estNext     = lkEst;
        end
      end else if (lkHit) begin
        if (!lkEst && (s1Swap != lkOrig)) begin
          stb.markEst = 1'b1;
          estNext     = 1'b1;
        end else begin
          stb.refresh = 1'b1;
          estNext     = lkEst;
        end
      end
    end
  end

  // Metadata handed to the stateless stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      metaValid   <= 1'b0;
      metaFromDmz <= 1'b0;
      metaEst     <= 1'b0;
    end else begin
      metaValid   <= s1Valid;
      metaFromDmz <= s1FromDmz;
      metaEst     <= estNext;
    end
  end

endmodule

// File: rtl/ct_filter.sv
module ct_filter (
  input  logic clk,
  input  logic rstN,
  input  logic metaValid,
  input  logic metaFromDmz,
  input  logic metaEst,
  output logic outValid,
  output logic outEstablished,
  output logic outAccept
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid       <= 1'b0;
      outEstablished <= 1'b0;
      outAccept      <= 1'b0;
    end else begin
      outValid       <= metaValid;
      outEstablished <= metaValid && metaEst;
      outAccept      <= metaValid && (!metaFromDmz || metaEst);
    end
  end

endmodule

// File: rtl/conn_track_filter.sv
module conn_track_filter
  import ct_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PORT_W     = 16,
  parameter int INDEX_W    = 4,
  parameter int IDLE_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inFromDmz,
  input  logic [ADDR_W-1:0] inSrcAddr,
  input  logic [ADDR_W-1:0] inDstAddr,
  input  logic [PORT_W-1:0] inSrcPort,
  input  logic [PORT_W-1:0] inDstPort,
  input  logic              ageTick,
  output logic              outValid,
  output logic              outEstablished,
  output logic              outAccept
);

  ctStrobe_t stb;
  logic s1Valid, s1FromDmz, s1Swap, lkHit, lkEst, lkOrig;
  logic metaValid, metaFromDmz, metaEst;

  ct_datapath #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .INDEX_W(INDEX_W), .IDLE_LIMIT(IDLE_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFromDmz(inFromDmz),
    .inSrcAddr(inSrcAddr), .inDstAddr(inDstAddr),
    .inSrcPort(inSrcPort), .inDstPort(inDstPort),
    .ageTick(ageTick), .stb(stb),
    .s1Valid(s1Valid), .s1FromDmz(s1FromDmz), .s1Swap(s1Swap),
    .lkHit(lkHit), .lkEst(lkEst), .lkOrig(lkOrig)
  );

  ct_control u_ctl (
    .clk(clk), .rstN(rstN), .s1Valid(s1Valid), .s1FromDmz(s1FromDmz),
    .s1Swap(s1Swap), .lkHit(lkHit), .lkEst(lkEst), .lkOrig(lkOrig),
    .stb(stb), .metaValid(metaValid), .metaFromDmz(metaFromDmz), .metaEst(metaEst)
  );

  ct_filter u_flt (
    .clk(clk), .rstN(rstN), .metaValid(metaValid), .metaFromDmz(metaFromDmz),
    .metaEst(metaEst), .outValid(outValid), .outEstablished(outEstablished),
    .outAccept(outAccept)
  );

endmodule

// File: rtl/ct_checker.sv
module ct_checker
  import ct_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      inValid,
  input logic      inFromDmz,
  input logic      outValid,
  input logic      outEstablished,
  input logic      outAccept,
  input ctStrobe_t stb,
  input logic      s1FromDmz
);

  // R1: verdict arrives three edges after the packet
  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid, 3));

  // R5: LAN-side packets always pass
  a_r5_lan_accept: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(inFromDmz, 3)) |-> outAccept);

  // R6: DMZ-side packets pass only when established
  a_r6_dmz_gate: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inFromDmz, 3)) |-> (outAccept == outEstablished));

  // R6: DMZ side never creates an entry
  a_r6_no_dmz_create: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrNew |-> !s1FromDmz);

  // R4: only a DMZ-side packet promotes an entry
  a_r4_promote_from_dmz: assert property (@(posedge clk) disable iff (!rstN)
    stb.markEst |-> s1FromDmz);

  // R3: at most one table action per cycle
  a_r3_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrNew, stb.markEst, stb.refresh}));

  // R9: no stray flags without a verdict
  a_r9_quiet_flags: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outAccept && !outEstablished));

endmodule

bind conn_track_filter ct_checker u_ct_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inFromDmz(inFromDmz),
  .outValid(outValid), .outEstablished(outEstablished), .outAccept(outAccept),
  .stb(stb), .s1FromDmz(s1FromDmz)
);

// File: tb/conn_track_filter_bench.sv
`timescale 1ns/1ps
module conn_track_filter_bench;

  localparam int ADDR_W = 32, PORT_W = 16, INDEX_W = 4, IDLE_LIMIT = 8;
  localparam int DEPTH = 1 << INDEX_W;
  localparam int EP_W = ADDR_W + PORT_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inFromDmz = 1'b0, ageTick = 1'b0;
  logic [ADDR_W-1:0] inSrcAddr = '0, inDstAddr = '0;
  logic [PORT_W-1:0] inSrcPort = '0, inDstPort = '0;
  logic outValid, outEstablished, outAccept;

  always #2.5 clk = ~clk;

  conn_track_filter #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .INDEX_W(INDEX_W), .IDLE_LIMIT(IDLE_LIMIT)
  ) u_conn_track_filter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFromDmz(inFromDmz),
    .inSrcAddr(inSrcAddr), .inDstAddr(inDstAddr),
    .inSrcPort(inSrcPort), .inDstPort(inDstPort), .ageTick(ageTick),
    .outValid(outValid), .outEstablished(outEstablished), .outAccept(outAccept)
  );

  int nChecks = 0;
  int nErrors = 0;

  // Reference model of the flow table
  logic [2*EP_W-1:0] mKey [DEPTH];
  bit mValid [DEPTH];
  bit mEst [DEPTH];
  bit mOrig [DEPTH];
  int mIdle [DEPTH];

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit modelPacket(input bit dmz, input logic [ADDR_W-1:0] sa, da,
                                     input logic [PORT_W-1:0] sp, dp);
    logic [EP_W-1:0] es, ed;
    logic [2*EP_W-1:0] k;
    bit sw, hit, est;
    int ix;
    es = {sa, sp};
    ed = {da, dp};
    sw = es > ed;
    k = sw ? {ed, es} : {es, ed};
    ix = int'((sp ^ dp) & PORT_W'(DEPTH - 1));
    hit = mValid[ix] && (mKey[ix] == k);
    est = 1'b0;
    if (!dmz) begin
      if (!hit) begin
        mValid[ix] = 1'b1; mKey[ix] = k; mEst[ix] = 1'b0; mOrig[ix] = sw; mIdle[ix] = 0;
      end else begin
        mIdle[ix] = 0;
        est = mEst[ix];
      end
    end else if (hit) begin
      if (!mEst[ix] && (sw != mOrig[ix])) mEst[ix] = 1'b1;
      mIdle[ix] = 0;
      est = mEst[ix];
    end
    return est;
  endfunction

  // Presents one packet at a falling edge and checks its verdict
  task automatic sendPkt(input string req, input bit dmz,
                         input logic [ADDR_W-1:0] sa, da,
                         input logic [PORT_W-1:0] sp, dp);
    bit expEst, expAcc;
    expEst = modelPacket(dmz, sa, da, sp, dp);
    expAcc = dmz ? expEst : 1'b1;
    inValid = 1'b1; inFromDmz = dmz;
    inSrcAddr = sa; inDstAddr = da; inSrcPort = sp; inDstPort = dp;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R1", "outValid at third edge", int'(outValid), 1);
    check(req, "outEstablished", int'(outEstablished), int'(expEst));
    check(req, "outAccept", int'(outAccept), int'(expAcc));
    @(posedge clk);
    @(negedge clk);
    check("R1", "outValid after verdict", int'(outValid), 0);
  endtask

  task automatic tick(input int n);
    for (int t = 0; t < n; t++) begin
      ageTick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ageTick = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (mValid[i]) begin
          mIdle[i]++;
          if (mIdle[i] == IDLE_LIMIT) begin
            mValid[i] = 1'b0; mEst[i] = 1'b0; mIdle[i] = 0;
          end
        end
      end
    end
  endtask

  localparam logic [31:0] LAN1 = 32'h0A00_0001, DMZ1 = 32'h1400_0005;
  localparam logic [31:0] LAN2 = 32'h0A00_0002, DMZ2 = 32'h1400_0006;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mValid[i] = 0; mEst[i] = 0; mOrig[i] = 0; mIdle[i] = 0; mKey[i] = '0;
    end
    void'($urandom(32'd20170403));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9", "outValid in reset", int'(outValid), 0);
    check("R9", "outAccept in reset", int'(outAccept), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "outEstablished after reset", int'(outEstablished), 0);

    // R3 and R5: LAN opens a flow; R4 and R2: reply with reversed tuple establishes it
    sendPkt("R3", 1'b0, LAN1, DMZ1, 16'd1000, 16'd80);
    sendPkt("R4", 1'b1, DMZ1, LAN1, 16'd80, 16'd1000);
    sendPkt("R5", 1'b0, LAN1, DMZ1, 16'd1000, 16'd80);
    sendPkt("R7", 1'b1, DMZ1, LAN1, 16'd80, 16'd1000);

    // R6: unsolicited DMZ traffic leaves no entry; a reverse DMZ packet is still dropped
    sendPkt("R6", 1'b1, DMZ2, LAN2, 16'd22, 16'd2000);
    sendPkt("R6", 1'b1, LAN2, DMZ2, 16'd2000, 16'd22);

    // R7: DMZ packet repeating the originator's direction does not establish
    sendPkt("R3", 1'b0, LAN2, DMZ2, 16'd3000, 16'd443);
    sendPkt("R7", 1'b1, LAN2, DMZ2, 16'd3000, 16'd443);
    sendPkt("R4", 1'b1, DMZ2, LAN2, 16'd443, 16'd3000);

    // R8: reply after IDLE_LIMIT-1 silent ticks is still in time
    sendPkt("R3", 1'b0, LAN1, DMZ2, 16'd4001, 16'd53);
    tick(IDLE_LIMIT - 1);
    sendPkt("R8", 1'b1, DMZ2, LAN1, 16'd53, 16'd4001);
    // R8: a flow silent for IDLE_LIMIT ticks is forgotten
    sendPkt("R3", 1'b0, LAN2, DMZ1, 16'd5002, 16'd25);
    tick(IDLE_LIMIT);
    sendPkt("R8", 1'b1, DMZ1, LAN2, 16'd25, 16'd5002);

    // R2: two flows sharing slot 0; the second LAN flow evicts the first
    sendPkt("R2", 1'b0, 32'h0A00_0009, 32'h1400_0009, 16'h0010, 16'h0020);
    sendPkt("R2", 1'b0, 32'h0A00_0008, 32'h1400_0008, 16'h0011, 16'h0021);
    sendPkt("R2", 1'b1, 32'h1400_0009, 32'h0A00_0009, 16'h0020, 16'h0010);
    sendPkt("R2", 1'b1, 32'h1400_0008, 32'h0A00_0008, 16'h0021, 16'h0011);

    // Random mix of LAN traffic, DMZ replies and aging
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [31:0] la, da;
      logic [15:0] lp, dp;
      r  = int'($urandom % 10);
      la = 32'h0A00_0000 + ($urandom % 4);
      da = 32'h1400_0000 + ($urandom % 4);
      lp = 16'd1000 + 16'($urandom % 4);
      dp = ($urandom % 2) ? 16'd80 : 16'd443;
      if (r == 0) tick(1);
      else if (r < 5) sendPkt("R5", 1'b0, la, da, lp, dp);
      else sendPkt("R6", 1'b1, da, la, dp, lp);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule